// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets a clocked host read and write an external asynchronous static RAM of 512K bytes (19-bit address, 8-bit data). The host offers one request at a time over a valid/ready handshake that carries an address, write data and a direction flag. Read results come back on a data bus with a one-cycle valid pulse. The external side uses three active-low strobes (chip select, write enable, output enable). The data bus is split into an output value, an output-drive enable and an input value, which a pad ring joins into one bidirectional bus.

Each access passes through three phases: setup, strobe and hold. Each phase lasts a whole number of clock cycles. These counts are worked out at elaboration from the clock period and the memory speed grade (55 ns or 70 ns). Each count is rounded up and is never below one cycle. During a write the output enable stays high, and the write window is bounded by write enable inside chip select. During a read, chip select and output enable frame the access time. The hold phase that follows a read gives the memory time to release the bus before the controller may drive it again.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, req_ready is 1 and rd_valid is 0.
- R2: Whenever req_ready is 1 (no access in progress), mem_cs_n is 1.
- R3: A write holds mem_we_n low for exactly ceil(max(write pulse, address-to-end, select-to-end, data-setup)/CLK_NS) cycles, which is 5 cycles at CLK_NS=10 and the 55 ns grade. Throughout that window mem_cs_n is 0, mem_dq_oe is 1 and mem_oe_n is 1.
- R4: mem_addr and mem_dq_out stay stable for the whole write window, and the byte written is the req_wdata accepted with that request, at req_addr.
- R5: A read holds mem_oe_n low for exactly ceil(access time/CLK_NS) cycles, which is 6 at the defaults. During those cycles mem_cs_n is 0 and mem_we_n is 1, and mem_dq_oe is 0 for the whole read.
- R6: Read data is sampled from mem_dq_in at the clock edge that ends the last output-enable-low cycle. It is presented on rd_data with rd_valid high for exactly one cycle per read and never for a write.
- R7: req_ready goes low on the cycle after acceptance and stays low until the hold phase ends. A write is then busy for 7 cycles and a read for 9 cycles at the defaults. A write's total is at least ceil(cycle time/CLK_NS).
- R8: After mem_oe_n rises, mem_dq_oe stays 0 for at least ceil(output-release time/CLK_NS) cycles, which is 2 at the defaults.
- R9: req_valid and the request fields are ignored while req_ready is 0. The access in progress keeps its address and data, and no extra access is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; a request is taken when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 8 | Read data |
| mem_addr | output | 19 | Address to the memory |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data returned by the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
A wrong phase counter shows up as a strobe pulse that is one or more cycles too short or too long. It also shows as a busy period that differs from 7 or 9 cycles, visible in the same transaction. A stale direction bit or a mis-timed capture shows within one access: either the wrong strobe falls, or the modelled memory returns placeholder data that has not yet become valid, which then appears on rd_data. A broken turnaround or a corrupted request register shows up as a drive overlap with output enable, or as a wrong byte on the next read-back of that address.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    // Rounded-up cycle count for a nanosecond figure, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Hold cycles that stretch a write to its minimum total cycle time.
    function automatic int unsigned tail_cycles(input int unsigned total, input int unsigned setup,
                                                input int unsigned strobe);
        return (total > setup + strobe) ? (total - setup - strobe) : 1;
    endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned WR_SETUP  = 1,
    parameter int unsigned WR_STROBE = 5,
    parameter int unsigned WR_HOLD   = 1,
    parameter int unsigned RD_SETUP  = 1,
    parameter int unsigned RD_STROBE = 6,
    parameter int unsigned RD_HOLD   = 2,
    parameter int unsigned CNT_W     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_write,
    output logic idle,
    output logic capture,
    output logic cs_n,
    output logic we_n,
    output logic oe_n,
    output logic dq_oe
);

    typedef struct packed {
        phase_e             phase;
        logic               write;
        logic [CNT_W-1:0]   cnt;
        logic               cs_n;
        logic               we_n;
        logic               oe_n;
        logic               dq_oe;
    } seq_t;

    seq_t seq_d, seq_q;
    logic capture_d;

    always_comb begin
        seq_d     = seq_q;
        capture_d = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start) begin
                    seq_d.phase = PH_SETUP;
                    seq_d.write = start_write;
                    seq_d.cnt   = start_write ? CNT_W'(WR_SETUP - 1) : CNT_W'(RD_SETUP - 1);
                end
            end
            PH_SETUP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_STROBE;
                    seq_d.cnt   = seq_q.write ? CNT_W'(WR_STROBE - 1) : CNT_W'(RD_STROBE - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_HOLD;
                    seq_d.cnt   = seq_q.write ? CNT_W'(WR_HOLD - 1) : CNT_W'(RD_HOLD - 1);
                    capture_d   = !seq_q.write;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
        // Strobes are registered from the next phase so the pins never glitch.
        seq_d.cs_n  = !(seq_d.phase == PH_SETUP || seq_d.phase == PH_STROBE);
        seq_d.we_n  = !(seq_d.write && seq_d.phase == PH_STROBE);
        seq_d.oe_n  = !(!seq_d.write && seq_d.phase == PH_STROBE);
        seq_d.dq_oe = seq_d.write && (seq_d.phase != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.phase <= PH_IDLE;
            seq_q.cs_n  <= 1'b1;
            seq_q.we_n  <= 1'b1;
            seq_q.oe_n  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idle    = (seq_q.phase == PH_IDLE);
    assign capture = capture_d;
    assign cs_n    = seq_q.cs_n;
    assign we_n    = seq_q.we_n;
    assign oe_n    = seq_q.oe_n;
    assign dq_oe   = seq_q.dq_oe;

    // R3
    write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.we_n |-> (!seq_q.cs_n && seq_q.oe_n && seq_q.dq_oe));

    // R5
    read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.oe_n |-> (!seq_q.cs_n && seq_q.we_n && !seq_q.dq_oe));

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              busy,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d        = dp_q;
        dp_d.rvalid = capture;
        if (accept) begin
            dp_d.addr  = req_addr;
            dp_d.wdata = req_wdata;
        end
        if (capture) begin
            dp_d.rdata = mem_dq_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign mem_addr   = dp_q.addr;
    assign mem_dq_out = dp_q.wdata;
    assign rd_valid   = dp_q.rvalid;
    assign rd_data    = dp_q.rdata;

    // R4 R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(dp_q.addr) && $stable(dp_q.wdata)));

    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_q.rvalid |=> !dp_q.rvalid);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned CLK_NS   = 10,
    parameter int unsigned SPEED_NS = 55,
    parameter int unsigned ADDR_W   = 19,
    parameter int unsigned DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n
);

    // Grade-dependent minimum and maximum times in ns.
    localparam bit          SLOW    = (SPEED_NS >= 70);
    localparam int unsigned T_CYC   = SLOW ? 70 : 55;
    localparam int unsigned T_PULSE = SLOW ? 50 : 40;
    localparam int unsigned T_ADEND = SLOW ? 60 : 45;
    localparam int unsigned T_CSEND = SLOW ? 60 : 45;
    localparam int unsigned T_DSET  = SLOW ? 30 : 25;
    localparam int unsigned T_REL   = SLOW ? 25 : 20;

    localparam int unsigned WR_SETUP  = 1;
    localparam int unsigned WR_STROBE = ns_to_cycles(max2(max2(T_PULSE, T_ADEND), max2(T_CSEND, T_DSET)), CLK_NS);
    localparam int unsigned WR_HOLD   = tail_cycles(ns_to_cycles(T_CYC, CLK_NS), WR_SETUP, WR_STROBE);
    localparam int unsigned RD_SETUP  = 1;
    localparam int unsigned RD_STROBE = ns_to_cycles(T_CYC, CLK_NS);
    localparam int unsigned RD_HOLD   = ns_to_cycles(T_REL, CLK_NS);
    localparam int unsigned MAX_LEN   = max2(max2(WR_STROBE, RD_STROBE), max2(WR_HOLD, RD_HOLD));
    localparam int unsigned CNT_W     = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

    logic idle, capture, accept;

    assign req_ready = idle;
    assign accept    = req_valid && idle;

    asram_seq #(
        .WR_SETUP  (WR_SETUP),
        .WR_STROBE (WR_STROBE),
        .WR_HOLD   (WR_HOLD),
        .RD_SETUP  (RD_SETUP),
        .RD_STROBE (RD_STROBE),
        .RD_HOLD   (RD_HOLD),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_write (req_write),
        .idle        (idle),
        .capture     (capture),
        .cs_n        (mem_cs_n),
        .we_n        (mem_we_n),
        .oe_n        (mem_oe_n),
        .dq_oe       (mem_dq_oe)
    );

    asram_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .busy       (!idle),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    // Cycles since output enable was last low, saturating; checker state only.
    localparam int unsigned GAP_W = CNT_W + 1;
    logic [GAP_W-1:0] gap_d, gap_q;

    always_comb begin
        if (!mem_oe_n)          gap_d = '0;
        else if (gap_q == '1)   gap_d = gap_q;
        else                    gap_d = gap_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= '1;
        else        gap_q <= gap_d;
    end

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (gap_q >= GAP_W'(RD_HOLD)));

    // R2
    idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n);

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int EXP_WE_LEN = 5;
    localparam int EXP_OE_LEN = 6;
    localparam int EXP_WR_BUSY = 7;
    localparam int EXP_RD_BUSY = 9;
    localparam int EXP_GAP    = 2;
    localparam int NVEC       = 10;

    // {write, addr[18:0], data[7:0]}; for reads data is the expected byte
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b1, 19'h00000, 8'hA5},
        {1'b1, 19'h7FFFF, 8'h3C},
        {1'b1, 19'h12345, 8'h00},
        {1'b1, 19'h2AAAA, 8'hFF},
        {1'b0, 19'h00000, 8'hA5},
        {1'b0, 19'h7FFFF, 8'h3C},
        {1'b0, 19'h2AAAA, 8'hFF},
        {1'b0, 19'h12345, 8'h00},
        {1'b1, 19'h00000, 8'h5A},
        {1'b0, 19'h00000, 8'h5A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [18:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in;
    logic        mem_cs_n, mem_we_n, mem_oe_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    asram_ctrl u_asram_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Memory model and port monitor, sampled at the falling edge.
    logic [7:0]  sram [int];
    logic [7:0]  dq_model = 8'hEE;
    int          we_run = 0, oe_run = 0, last_we = 0, last_oe = 0;
    int          since_oe = 1000, min_gap = 1000;
    logic        prev_dq_oe = 1'b0;
    logic        pend = 1'b0;
    logic [18:0] pend_a = '0;
    logic [7:0]  pend_d = '0;
    logic [18:0] win_a = '0;
    int          addr_moves = 0, strobe_bad = 0, idle_sel = 0, clash = 0;

    assign mem_dq_in = dq_model;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) begin
                if (we_run > 0 && (mem_addr != win_a || mem_dq_out != pend_d)) addr_moves++;
                we_run++;
            end else if (we_run != 0) begin
                last_we = we_run;
                we_run = 0;
            end
            if (!mem_oe_n) oe_run++;
            else if (oe_run != 0) begin
                last_oe = oe_run;
                oe_run = 0;
            end
            if ((!mem_we_n || !mem_oe_n) && mem_cs_n) strobe_bad++;
            if (req_ready && !mem_cs_n) idle_sel++;
            if (mem_dq_oe && !mem_oe_n) clash++;
            if (!mem_oe_n) since_oe = 0;
            else since_oe++;
            if (mem_dq_oe && !prev_dq_oe && since_oe < min_gap) min_gap = since_oe;
            prev_dq_oe = mem_dq_oe;
            // write commits when the window closes
            if (!mem_cs_n && !mem_we_n) begin
                win_a  = mem_addr;
                pend_a = mem_addr;
                pend_d = mem_dq_oe ? mem_dq_out : 8'hXX;
                pend   = 1'b1;
            end else if (pend) begin
                sram[int'(pend_a)] = pend_d;
                pend = 1'b0;
            end
            // data becomes valid only after the full access time
            if (!mem_cs_n && !mem_oe_n && mem_we_n && oe_run >= EXP_OE_LEN)
                dq_model = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 8'h00;
            else
                dq_model = 8'hEE;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    int         busy_n, valid_n;
    logic [7:0] got;

    task automatic do_req(input bit wr, input logic [18:0] a, input logic [7:0] d, input bit noise);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        busy_n  = 0;
        valid_n = 0;
        got     = 8'h00;
        @(negedge clk);
        if (noise) begin
            req_write = 1'b1;
            req_addr  = 19'h55555;
            req_wdata = 8'h77;
        end else begin
            req_valid = 1'b0;
        end
        while (!req_ready) begin
            busy_n++;
            if (rd_valid) begin
                valid_n++;
                got = rd_data;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (rd_valid) valid_n++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "cs_n in reset", int'(mem_cs_n), 1);
        chk("R1", "we_n in reset", int'(mem_we_n), 1);
        chk("R1", "oe_n in reset", int'(mem_oe_n), 1);
        chk("R1", "dq_oe in reset", int'(mem_dq_oe), 0);
        chk("R1", "ready in reset", int'(req_ready), 1);
        chk("R1", "rd_valid in reset", int'(rd_valid), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic       wr;
            logic [18:0] a;
            logic [7:0] d;
            wr = VEC[i][27];
            a  = VEC[i][26:8];
            d  = VEC[i][7:0];
            do_req(wr, a, d, 1'b0);
            if (wr) begin
                chk("R3", "write strobe length", last_we, EXP_WE_LEN);
                chk("R7", "write busy cycles", busy_n, EXP_WR_BUSY);
                chk("R6", "no valid on write", valid_n, 0);
            end else begin
                chk("R5", "read strobe length", last_oe, EXP_OE_LEN);
                chk("R7", "read busy cycles", busy_n, EXP_RD_BUSY);
                chk("R6", "valid pulses per read", valid_n, 1);
                chk("R4", "read-back byte", int'(got), int'(d));
            end
        end
        chk("R8", "min oe-release to drive gap >= 2", int'(min_gap >= EXP_GAP), 1);

        // R9: request held during a busy read is ignored
        do_req(1'b0, 19'h12345, 8'h00, 1'b1);
        chk("R9", "read data under stray request", int'(got), 8'h00);
        chk("R9", "valid pulses under stray request", valid_n, 1);
        chk("R9", "stray address not written", int'(sram.exists(int'(19'h55555))), 0);
        chk("R9", "busy cycles under stray request", busy_n, EXP_RD_BUSY);
        repeat (4) @(negedge clk);
        chk("R9", "no access started afterwards", int'(mem_cs_n), 1);

        // back-to-back write after read at the top address
        do_req(1'b1, 19'h7FFFF, 8'hC3, 1'b0);
        do_req(1'b0, 19'h7FFFF, 8'h00, 1'b0);
        chk("R4", "top address overwrite", int'(got), 8'hC3);

        chk("R2", "select while idle", idle_sel, 0);
        chk("R3", "strobe outside select", strobe_bad, 0);
        chk("R4", "address or data moved in window", addr_moves, 0);
        chk("R5", "drive during output enable", clash, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule